// File: doc/BRIEF.md
# ADC Output Power-Down and Wake Sequencer

This block sits between a converter's decimation datapath and its serial output stage. It watches an active-low power-down request and a flag that says the external clocks are running. While either one calls for power-down, it holds the filter datapath in reset and drives every output sample to two's complement zero.

When the request clears, the block leaves reset and counts rising edges of the frame clock (the once-per-sample word clock) for a fixed initialization window. Outputs stay at zero for the whole window. After the window it passes live samples and raises a valid flag.

Raw results arrive wider than the output word. On the way out the block clamps any value that will not fit to the nearest full-scale code, so a large excursion never wraps around to the wrong sign.

Top module: `adc_wake_seq`

## Requirements
- R1: While `rst_n` is low, `dp_rst` is 1, `out_valid` is 0 and every output sample is 0.
- R2: When `pd_n` is held low for two or more system clocks, the block enters power-down. In power-down `dp_rst` is 1, `out_valid` is 0, all samples are 0 and the frame counter is cleared.
- R3: A low pulse on `pd_n` lasting a single system clock has no effect. `dp_rst` stays 0 and `out_valid` stays 1.
- R4: Once power-down is released, `dp_rst` drops to 0 and outputs stay at zero with `out_valid` 0 through INIT_FRAMES frame-clock rising edges. `out_valid` rises with the next rising edge, which is edge INIT_FRAMES+1.
- R5: While `out_valid` is 1, each channel's output is its input one system clock later, whenever the input fits in OUT_W signed bits. This includes exactly 7FFFFF and 800000 hex.
- R6: In the run state, an input above +(2^(OUT_W-1)-1) outputs 7FFFFF hex.
- R7: In the run state, an input below -(2^(OUT_W-1)) outputs 800000 hex.
- R8: When `clocks_ok` is 0 at a clock edge, the block is in power-down after that edge, with `dp_rst` 1 and `out_valid` 0.
- R9: Asserting power-down during initialization restarts the count. After release, the full INIT_FRAMES+1 edges are needed again.
- R10: Only rising edges of `frame_clk` advance the count. Falling edges are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, applied once after power-up |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| frame_clk | input | 1 | Frame (sample-rate) clock, sampled in the system clock domain |
| clocks_ok | input | 1 | High while the external clocks are present |
| smp_i | input | NUM_CH*IN_W | Raw signed samples; channel 0 in the low bits |
| dp_rst | output | 1 | Reset to the filter datapath |
| out_valid | output | 1 | High while live samples are passed |
| smp_o | output | NUM_CH*OUT_W | Gated, saturated samples; channel 0 in the low bits |

## Verification
The bench builds the block with INIT_FRAMES=5, two channels, IN_W=28 and OUT_W=24. The short window lets the bench walk every frame edge of the initialization and then watch the valid flag rise exactly on edge six. The same short window makes it practical to restart initialization part-way through and run it again. The four extra input bits give room for codes past both full-scale limits, so both clamps and both exact-limit codes are driven through the output path.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        ST_PDOWN = 2'd0,
        ST_INIT  = 2'd1,
        ST_RUN   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/adc_pd_filter.sv
// Synchronizes the active-low power-down request, then confirms it only
// after it has been seen low on two consecutive synchronized samples.
module adc_pd_filter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_n,
    output logic pd_low
);
    logic [SYNC_STAGES-1:0] sync_q, sync_d;
    logic                   hist_q, hist_d;

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], pd_n};
        hist_d = sync_q[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            hist_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            hist_q <= hist_d;
        end
    end

    assign pd_low = !sync_q[SYNC_STAGES-1] && !hist_q;
endmodule

// File: rtl/adc_edge_det.sv
// Brings the frame clock into the system domain and flags its rising edges.
module adc_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise
);
    logic [SYNC_STAGES-1:0] sync_q, sync_d;
    logic                   prev_q, prev_d;

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], sig_i};
        prev_d = sync_q[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign rise = sync_q[SYNC_STAGES-1] && !prev_q;
endmodule

// File: rtl/adc_sat.sv
// Clamps a wide signed value to the nearest OUT_W-bit full-scale code.
module adc_sat #(
    parameter int IN_W  = 28,
    parameter int OUT_W = 24
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    localparam int HEAD_W = IN_W - OUT_W + 1;
    localparam logic [OUT_W-1:0] POS_FS = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_FS = {1'b1, {(OUT_W-1){1'b0}}};

    logic [HEAD_W-1:0] head;
    logic              fits;

    always_comb begin
        head = din[IN_W-1:OUT_W-1];
        fits = (head == '0) || (head == '1);
        if (fits)
            dout = din[OUT_W-1:0];
        else if (din[IN_W-1])
            dout = NEG_FS;
        else
            dout = POS_FS;
    end
endmodule

// File: rtl/adc_wake_seq.sv
module adc_wake_seq
    import adc_seq_pkg::*;
#(
    parameter int INIT_FRAMES = 4129,
    parameter int NUM_CH      = 2,
    parameter int IN_W        = 28,
    parameter int OUT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pd_n,
    input  logic                    frame_clk,
    input  logic                    clocks_ok,
    input  logic [NUM_CH*IN_W-1:0]  smp_i,
    output logic                    dp_rst,
    output logic                    out_valid,
    output logic [NUM_CH*OUT_W-1:0] smp_o
);
    localparam int CNT_W = $clog2(INIT_FRAMES + 1);
    localparam int SMP_W = NUM_CH * OUT_W;
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(INIT_FRAMES);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             vld;
        logic [SMP_W-1:0] smp;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             pd_low;
    logic             fr_rise;
    logic             pd_req;
    logic [SMP_W-1:0] sat_w;

    adc_pd_filter #(.SYNC_STAGES(SYNC_STAGES)) u_pd (
        .clk    (clk),
        .rst_n  (rst_n),
        .pd_n   (pd_n),
        .pd_low (pd_low)
    );

    adc_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_frame (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_i (frame_clk),
        .rise  (fr_rise)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        adc_sat #(.IN_W(IN_W), .OUT_W(OUT_W)) u_sat (
            .din  (smp_i[ch*IN_W +: IN_W]),
            .dout (sat_w[ch*OUT_W +: OUT_W])
        );
    end

    assign pd_req = pd_low || !clocks_ok;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_PDOWN: begin
                seq_d.cnt = '0;
                if (!pd_req) seq_d.st = ST_INIT;
            end
            ST_INIT: begin
                if (fr_rise) begin
                    if (seq_q.cnt == CNT_END)
                        seq_d.st = ST_RUN;
                    else
                        seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_RUN:  seq_d.st = ST_RUN;
            default: seq_d.st = ST_PDOWN;
        endcase
        if (pd_req) begin
            seq_d.st  = ST_PDOWN;
            seq_d.cnt = '0;
        end
        seq_d.vld = (seq_d.st == ST_RUN);
        seq_d.smp = seq_d.vld ? sat_w : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st  <= ST_PDOWN;
            seq_q.cnt <= '0;
            seq_q.vld <= 1'b0;
            seq_q.smp <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign dp_rst    = (seq_q.st == ST_PDOWN);
    assign out_valid = seq_q.vld;
    assign smp_o     = seq_q.smp;
endmodule

// File: rtl/adc_wake_seq_chk.sv
module adc_wake_seq_chk #(
    parameter int SW = 48
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clocks_ok,
    input logic          fr_rise,
    input logic          dp_rst,
    input logic          out_valid,
    input logic [SW-1:0] smp_o
);
    // R2
    reset_excludes_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_rst |-> !out_valid);

    // R4
    zero_when_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (smp_o == '0));

    // R10
    valid_on_frame_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(fr_rise));

    // R8
    clock_loss_pdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clocks_ok |=> dp_rst);

    // R9
    no_direct_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_rst |=> !out_valid);
endmodule

bind adc_wake_seq adc_wake_seq_chk #(.SW(NUM_CH*OUT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clocks_ok (clocks_ok),
    .fr_rise   (fr_rise),
    .dp_rst    (dp_rst),
    .out_valid (out_valid),
    .smp_o     (smp_o)
);

// File: tb/test_adc_wake_seq.sv
module test_adc_wake_seq;
    localparam int INIT_FRAMES = 5;
    localparam int NUM_CH      = 2;
    localparam int IN_W        = 28;
    localparam int OUT_W       = 24;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    pd_n = 1'b0;
    logic                    frame_clk = 1'b0;
    logic                    clocks_ok = 1'b1;
    logic [NUM_CH*IN_W-1:0]  smp_i = '0;
    logic                    dp_rst;
    logic                    out_valid;
    logic [NUM_CH*OUT_W-1:0] smp_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [NUM_CH*OUT_W-1:0] smp;
        string                   tag;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    adc_wake_seq #(
        .INIT_FRAMES(INIT_FRAMES), .NUM_CH(NUM_CH), .IN_W(IN_W), .OUT_W(OUT_W)
    ) i_adc_wake_seq (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .frame_clk(frame_clk),
        .clocks_ok(clocks_ok), .smp_i(smp_i), .dp_rst(dp_rst),
        .out_valid(out_valid), .smp_o(smp_o)
    );

    function automatic logic [OUT_W-1:0] model_sat(logic signed [IN_W-1:0] x);
        if (x > 28'sd8388607)       return 24'h7FFFFF;
        else if (x < -28'sd8388608) return 24'h800000;
        else                        return x[OUT_W-1:0];
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // driver: apply one sample pair and queue the expected output
    task automatic drive_smp(logic signed [IN_W-1:0] l, logic signed [IN_W-1:0] r, string tag);
        exp_t e;
        @(negedge clk);
        smp_i = {r, l};
        e.smp = {model_sat(r), model_sat(l)};
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: result registered on the edge after the drive
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(out_valid === 1'b1, {e.tag, " valid"}, 64'(out_valid), 64'd1);
            chk(smp_o === e.smp, e.tag, 64'(smp_o), 64'(e.smp));
        end
    end

    task automatic frame_cycle();
        @(negedge clk);
        frame_clk = 1'b1;
        repeat (3) @(negedge clk);
        frame_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_init(string tag);
        for (int k = 0; k < INIT_FRAMES; k++) begin
            frame_cycle();
            chk(!out_valid && smp_o == '0, {tag, " R4 zero during init"},
                64'({out_valid, smp_o}), 64'd0);
        end
        frame_cycle();
        chk(out_valid === 1'b1, {tag, " R4 R10 valid after final rise"},
            64'(out_valid), 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(dp_rst === 1'b1 && out_valid === 1'b0 && smp_o == '0, "R1 reset state",
            64'({dp_rst, out_valid}), 64'b10);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        // R2 held in power-down
        chk(dp_rst === 1'b1 && out_valid === 1'b0, "R2 power-down held",
            64'({dp_rst, out_valid}), 64'b10);

        smp_i = {28'sd77, 28'sd1234};
        pd_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(dp_rst === 1'b0, "R4 datapath reset released", 64'(dp_rst), 64'd0);
        run_init("first");

        // R5 R6 R7 sample path
        drive_smp(28'sd1000, -28'sd2000, "R5 in range");
        drive_smp(28'sd8388607, -28'sd8388608, "R5 exact limits");
        drive_smp(28'sd8388608, 28'sd50000000, "R6 above positive");
        drive_smp(-28'sd8388609, -28'sd60000000, "R7 below negative");
        drive_smp(28'sd0, 28'sd9000000, "R6 mixed channels");
        drive_smp(-28'sd1, -28'sd9000000, "R7 mixed channels");
        @(negedge clk);
        @(negedge clk);

        // R3 single-clock glitch ignored
        @(negedge clk) pd_n = 1'b0;
        @(negedge clk) pd_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(dp_rst === 1'b0 && out_valid === 1'b1, "R3 glitch ignored",
            64'({dp_rst, out_valid}), 64'b01);
        drive_smp(28'sd42, -28'sd42, "R3 samples still pass");
        @(negedge clk);

        // R2 real power-down
        @(negedge clk) pd_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(dp_rst === 1'b1 && out_valid === 1'b0 && smp_o == '0, "R2 power-down entered",
            64'({dp_rst, out_valid}), 64'b10);
        pd_n = 1'b1;
        repeat (6) @(negedge clk);

        // R9 restart part-way through initialization
        repeat (3) frame_cycle();
        chk(out_valid === 1'b0, "R9 still initializing", 64'(out_valid), 64'd0);
        @(negedge clk) pd_n = 1'b0;
        repeat (4) @(negedge clk);
        pd_n = 1'b1;
        repeat (6) @(negedge clk);
        run_init("R9 restart");

        // R8 clock loss
        @(negedge clk) clocks_ok = 1'b0;
        @(negedge clk);
        chk(dp_rst === 1'b1 && out_valid === 1'b0, "R8 clock loss power-down",
            64'({dp_rst, out_valid}), 64'b10);
        clocks_ok = 1'b1;
        repeat (6) @(negedge clk);
        run_init("R8 recovery");
        drive_smp(-28'sd700000, 28'sd700000, "R5 after recovery");
        repeat (3) @(negedge clk);
        summary();
    end
endmodule